// File: doc/BRIEF.md
# Masked Open-Drain Line Register

This block is one register that controls two open-drain lines, a clock line and a data line, so that software can drive a two-wire serial bus bit by bit. Each line has its own byte in the register. A write to that byte carries a direction bit and an output value bit. Each of those two fields has its own write-enable (mask) bit in the same write, and a field changes only when its mask bit is set. The line is pulled low only when its direction is output and its value is 0. In every other state the pad is released and an external or pad pull-up brings the line high. The block never drives a line high.

A read returns the stored direction and value of each line, plus a pull-up-disable bit for each line. It also returns the level seen at each pad, taken through a synchroniser, whatever the direction. The pull-up-disable bits are plain state and take the written value on every write. Software reads the register first and writes those bits back unchanged. Mask bits are never stored and always read as 0.

Register layout: the clock line uses bits 7:0 and the data line uses bits 15:8. Within each byte, at offset b:
- b+0: direction mask.
- b+1: direction, where 1 means output.
- b+2: value mask.
- b+3: output value.
- b+4: synchronised pad level, read-only.
- b+5: pull-up disable.

Bits b+6 and b+7 read 0.

Top module: `odline_reg`

## Requirements
- R1: The direction bit of a line (offset 1) is loaded from the write only when that line's direction mask (offset 0) is 1 in the same write. Otherwise it keeps its value.
- R2: The output value bit of a line (offset 3) is loaded from the write only when that line's value mask (offset 2) is 1 in the same write. Otherwise it keeps its value.
- R3: When a line's direction is input (0), the line is released: `lineDriveLow` for that line is 0, whatever its value bit holds.
- R4: When a line's direction is output (1) and its value is 0, `lineDriveLow` for that line is 1. When the direction is output and the value is 1, the line is released and is never driven high.
- R5: The read-only pad bit (offset 4) shows the level of `lineIn` for that line through a two-flop synchroniser, whatever the direction. A pad change is visible after the second rising clock edge and not after the first.
- R6: Each line's pull-up-disable bit (offset 5) takes the written value on every write, with no mask. It reads back at offset 5 and appears on `pullupDis`.
- R7: Mask bits (offsets 0 and 2) and the unused offsets 6 and 7 always read as 0.
- R8: While reset is asserted and right after it, both directions are input, both values are 0, both pull-up-disable bits are 0, and both synchroniser outputs are 0. `rdData` is therefore 0 during reset.
- R9: A write that sets only the masks of one line leaves the direction and value of the other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| wrData | input | 16 | Write data: two line bytes with masks, fields and pull-up disables |
| rdData | output | 16 | Read data: stored fields and synchronised pad levels |
| lineIn | input | 2 | Pad level of each line, bit 0 clock, bit 1 data |
| lineDriveLow | output | 2 | Pull-down enable of each line's open-drain pad |
| pullupDis | output | 2 | Pull-up disable of each line's pad |

## Verification
Writes that set a field bit without its mask are checked through the readback. A design that ignored the mask would flip the direction or value, and an open-drain line could fall with no request. A write with direction output and value 1 checks that the line stays released; a design that drove from the value bit alone would pull it low or drive it high. A pad change is sampled after one edge and again after two edges. A design with one flop too few or too many would show the level a cycle early or late. Writes with both masks clear check that the pull-up-disable bits still follow the written value, and that masking one line's byte leaves the other line's fields alone.

// File: rtl/odline_pkg.sv
package odline_pkg;
  localparam int LINE_COUNT  = 2;
  localparam int LANE_STRIDE = 8;
  localparam int REG_W       = LINE_COUNT * LANE_STRIDE;

  localparam int OFS_DIR_MASK = 0;
  localparam int OFS_DIR      = 1;
  localparam int OFS_VAL_MASK = 2;
  localparam int OFS_VAL      = 3;
  localparam int OFS_IN       = 4;
  localparam int OFS_PUD      = 5;

  typedef struct packed {
    logic [LINE_COUNT-1:0] dirWe;
    logic [LINE_COUNT-1:0] dirNew;
    logic [LINE_COUNT-1:0] valWe;
    logic [LINE_COUNT-1:0] valNew;
    logic                  pudWe;
    logic [LINE_COUNT-1:0] pudNew;
  } strobe_t;
endpackage

// File: rtl/odline_ctl.sv
module odline_ctl
  import odline_pkg::*;
(
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output strobe_t          strb
);
  always_comb begin
    strb       = '0;
    strb.pudWe = wrEn;
    for (int i = 0; i < LINE_COUNT; i++) begin
      strb.dirWe[i]  = wrEn && wrData[i*LANE_STRIDE + OFS_DIR_MASK];
      strb.valWe[i]  = wrEn && wrData[i*LANE_STRIDE + OFS_VAL_MASK];
      strb.dirNew[i] = wrData[i*LANE_STRIDE + OFS_DIR];
      strb.valNew[i] = wrData[i*LANE_STRIDE + OFS_VAL];
      strb.pudNew[i] = wrData[i*LANE_STRIDE + OFS_PUD];
    end
  end
endmodule

// File: rtl/odline_dp.sv
module odline_dp
  import odline_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [LINE_COUNT-1:0] lineIn,
  output logic [REG_W-1:0]      rdData,
  output logic [LINE_COUNT-1:0] lineDriveLow,
  output logic [LINE_COUNT-1:0] pullupDis
);
  logic [LINE_COUNT-1:0] dirQ;
  logic [LINE_COUNT-1:0] valQ;
  logic [LINE_COUNT-1:0] pudQ;
  logic [LINE_COUNT-1:0] padSync;

  for (genvar g = 0; g < LINE_COUNT; g++) begin : g_lane
    logic [SYNC_STAGES-1:0] syncQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirQ[g] <= 1'b0;
        valQ[g] <= 1'b0;
        pudQ[g] <= 1'b0;
        syncQ   <= '0;
      end else begin
        if (strb.dirWe[g]) dirQ[g] <= strb.dirNew[g];
        if (strb.valWe[g]) valQ[g] <= strb.valNew[g];
        if (strb.pudWe)    pudQ[g] <= strb.pudNew[g];
        syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn[g]};
      end
    end

    assign padSync[g]      = syncQ[SYNC_STAGES-1];
    // open drain: pull low only when driving a zero, otherwise release
    assign lineDriveLow[g] = dirQ[g] & ~valQ[g];
    assign pullupDis[g]    = pudQ[g];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < LINE_COUNT; i++) begin
      rdData[i*LANE_STRIDE + OFS_DIR] = dirQ[i];
      rdData[i*LANE_STRIDE + OFS_VAL] = valQ[i];
      rdData[i*LANE_STRIDE + OFS_IN]  = padSync[i];
      rdData[i*LANE_STRIDE + OFS_PUD] = pudQ[i];
    end
  end
endmodule

// File: rtl/odline_reg.sv
module odline_reg
  import odline_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic [1:0]  lineIn,
  output logic [1:0]  lineDriveLow,
  output logic [1:0]  pullupDis
);
  strobe_t strb;

  odline_ctl u_ctl (
    .wrEn   (wrEn),
    .wrData (wrData),
    .strb   (strb)
  );

  odline_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .lineIn       (lineIn),
    .rdData       (rdData),
    .lineDriveLow (lineDriveLow),
    .pullupDis    (pullupDis)
  );
endmodule

// File: rtl/odline_checker.sv
module odline_checker
  import odline_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic [1:0]  lineIn,
  input logic [1:0]  lineDriveLow,
  input logic [1:0]  pullupDis
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  for (genvar g = 0; g < LINE_COUNT; g++) begin : g_chk
    localparam int B = g * LANE_STRIDE;

    p_dir_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
      !(wrEn && wrData[B+OFS_DIR_MASK]) |=> $stable(rdData[B+OFS_DIR]));
    p_dir_load_r1: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrData[B+OFS_DIR_MASK]) |=> rdData[B+OFS_DIR] == $past(wrData[B+OFS_DIR]));
    p_val_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      !(wrEn && wrData[B+OFS_VAL_MASK]) |=> $stable(rdData[B+OFS_VAL]));
    p_release_r3: assert property (@(posedge clk) disable iff (!rstN)
      !rdData[B+OFS_DIR] |-> !lineDriveLow[g]);
    p_pull_low_r4: assert property (@(posedge clk) disable iff (!rstN)
      (rdData[B+OFS_DIR] && !rdData[B+OFS_VAL]) |-> lineDriveLow[g]);
    p_no_high_r4: assert property (@(posedge clk) disable iff (!rstN)
      rdData[B+OFS_VAL] |-> !lineDriveLow[g]);
    p_pud_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
      wrEn |=> pullupDis[g] == $past(wrData[B+OFS_PUD]));
    p_mask_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
      wrEn |=> !rdData[B+OFS_DIR_MASK] && !rdData[B+OFS_VAL_MASK]);

    if (SYNC_STAGES == 2) begin : g_sync
      p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rstN)
        (age >= 2'd2) |-> rdData[B+OFS_IN] == $past(lineIn[g], 2));
    end
  end
endmodule

bind odline_reg odline_checker #(.SYNC_STAGES(SYNC_STAGES)) u_odline_checker (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .rdData       (rdData),
  .lineIn       (lineIn),
  .lineDriveLow (lineDriveLow),
  .pullupDis    (pullupDis)
);

// File: tb/odline_reg_bench.sv
`timescale 1ns/1ps
module odline_reg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  lineIn;
  logic [1:0]  lineDriveLow;
  logic [1:0]  pullupDis;
  logic [1:0]  extLow = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // pad model: wired-AND of the block's pull-down, an external pull-down and a pull-up
  assign lineIn = ~(lineDriveLow | extLow);

  odline_reg u_odline_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .lineIn(lineIn), .lineDriveLow(lineDriveLow), .pullupDis(pullupDis)
  );

  // {write data, expected readback without pad bits, expected drive-low, expected pull-up disable}
  localparam logic [35:0] TBL [12] = '{
    {16'h000F, 16'h000A, 2'b00, 2'b00},  // R4 lane0 output value 1: released
    {16'h0004, 16'h0002, 2'b01, 2'b00},  // R4 value 0 pulls low
    {16'h0002, 16'h0002, 2'b01, 2'b00},  // R1 direction bit without mask ignored
    {16'h0008, 16'h0002, 2'b01, 2'b00},  // R2 value bit without mask ignored
    {16'h0001, 16'h0000, 2'b00, 2'b00},  // R3 back to input releases
    {16'h0700, 16'h0200, 2'b10, 2'b00},  // R9 lane1 only
    {16'h2020, 16'h2220, 2'b10, 2'b11},  // R6 pull-up disables, no masks
    {16'h0000, 16'h0200, 2'b10, 2'b00},  // R6 cleared by plain write
    {16'h0D05, 16'h0800, 2'b00, 2'b00},  // R3 lane1 input with value 1
    {16'h0F0F, 16'h0A0A, 2'b00, 2'b00},  // R4 never drives high
    {16'h0707, 16'h0202, 2'b11, 2'b00},  // R4 both low
    {16'h0101, 16'h0000, 2'b00, 2'b00}   // R3 both released
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset rdData", rdData, 16'h0000);
    check("R8 reset lineDriveLow", {14'd0, lineDriveLow}, 16'h0000);
    check("R8 reset pullupDis", {14'd0, pullupDis}, 16'h0000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 R5 released lines read high", rdData, 16'h1010);

    for (int k = 0; k < 12; k++) begin
      logic [35:0] e;
      logic [15:0] expRd;
      e = TBL[k];
      doWrite(e[35:20]);
      expRd = e[19:4];
      expRd[4]  = ~e[2];
      expRd[12] = ~e[3];
      check("R1 R2 R5 R7 readback", rdData, expRd);
      check("R3 R4 lineDriveLow", {14'd0, lineDriveLow}, {14'd0, e[3:2]});
      check("R6 pullupDis", {14'd0, pullupDis}, {14'd0, e[1:0]});
    end

    // R5: two-edge synchroniser latency on a released line
    @(negedge clk);
    extLow[0] = 1'b1;
    @(negedge clk);
    check("R5 one edge not yet visible", {15'd0, rdData[4]}, 16'd1);
    @(negedge clk);
    check("R5 visible after two edges", {15'd0, rdData[4]}, 16'd0);
    check("R5 other line unaffected", {15'd0, rdData[12]}, 16'd1);
    extLow[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 recovers high", rdData, 16'h1010);

    // R9: lane0 masks only, lane1 fields set without masks
    doWrite(16'h0A07);
    check("R9 lane1 untouched", rdData, 16'h1002);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1..all act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule